// File: doc/BRIEF.md
# Latched Threshold Alarm Unit

This block watches two running counters, an elapsed-time count and an event count, and compares each against its own programmable limit. Each comparison yields a live flag that is set while the counter is at or above its limit and drops on its own once the counter falls below it. A limit of zero switches its comparison off. Both flags and the filtered event input level are reported in a status byte.

The flags feed a latched alarm output. When a flag whose enable bit is set becomes true, the alarm goes active and stays active even after the flag clears. Only a clear strobe, raised by a command write, releases it, and the alarm re-asserts at once if an enabled condition is still present. The pin is modelled as an open-drain output, as a drive-enable (pull low) plus the level seen on the line with a pull-up. A polarity bit selects whether the active state is the driven-low or the released level.

Top module: `threshold_alarm`

## Requirements
- R1: After reset the status byte reads 0x00 and the alarm is inactive; with the polarity bit at 0 this means alarmDriveEn=0 and alarmPin=1.
- R2: Status bit 0 (time flag) is 1 exactly when timeLimit is nonzero and timeCount >= timeLimit, one clock after the inputs are applied; it clears by itself when the count falls below the limit.
- R3: Status bit 1 (event flag) is 1 exactly when eventLimit is nonzero and eventCount >= eventLimit, one clock after the inputs are applied.
- R4: A limit of zero keeps its flag at 0 for every counter value.
- R5: Status bit 2 carries the event input level one clock after it is applied; status bits 7 to 3 always read 0.
- R6: Configuration bit 2 enables the time flag and bit 1 the event flag as alarm sources; one clock after an enabled flag reads 1 the alarm is active. A flag whose enable is 0 never activates the alarm.
- R7: Once active, the alarm stays active after its flag clears, as long as no clear strobe is given.
- R8: A clear strobe makes the alarm inactive in the next cycle when no enabled flag is set; if an enabled flag is set in that cycle, the alarm stays active (set wins over clear).
- R9: Configuration bit 0 is the polarity: with 0, active means alarmDriveEn=1 and alarmPin=0 and inactive means released; with 1, active means released (alarmDriveEn=0, alarmPin=1) and inactive means driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeCount | input | TIME_W | Working elapsed-time counter value |
| eventCount | input | EVT_W | Working event counter value |
| eventLevel | input | 1 | Filtered event input level |
| cfgByte | input | 8 | Bit 2 time enable, bit 1 event enable, bit 0 polarity |
| timeLimit | input | TIME_W | Time limit, zero disables |
| eventLimit | input | EVT_W | Event limit, zero disables |
| clearStrobe | input | 1 | One-cycle alarm release from a command write |
| statusByte | output | 8 | Bit 0 time flag, bit 1 event flag, bit 2 event level |
| alarmDriveEn | output | 1 | 1 pulls the alarm line low |
| alarmPin | output | 1 | Level on the alarm line with its pull-up |

## Verification
The comparators are swept over every pair of counter and limit values in a narrowed configuration, so equality, one-below and one-above cases and the zero-limit disable are all told apart from a plain greater-than or an always-on compare. The alarm is then walked through set, hold after the flag drops, clear with the condition gone, and clear with the condition still present, which separates a true latch from a flag follower and set priority from clear priority. Each source is tried with its enable off, and both polarities are read in the active and inactive states to catch an inverted drive.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int CFG_POL     = 0;
  localparam int CFG_EVT_EN  = 1;
  localparam int CFG_TIME_EN = 2;

  // Strobes from control to datapath for the alarm latch
  typedef struct packed {
    logic setAlarm;
    logic clearAlarm;
  } alarmStrobe_t;
endpackage

// File: rtl/limit_compare.sv
module limit_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] count,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic limitOn;
  assign limitOn = |limit;
  assign hit     = limitOn && (count >= limit);
endmodule

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int EVT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] timeCount,
  input  logic [EVT_W-1:0]  eventCount,
  input  logic              eventLevel,
  input  logic [TIME_W-1:0] timeLimit,
  input  logic [EVT_W-1:0]  eventLimit,
  input  logic              polarity,
  input  alarmStrobe_t      strobe,
  output logic              timeFlag,
  output logic              eventFlag,
  output logic [7:0]        statusByte,
  output logic              alarmDriveEn,
  output logic              alarmPin
);
  logic timeHit, eventHit, levelQ, alarmLatch;

  limit_compare #(.W(TIME_W)) uTimeCmp (
    .count(timeCount), .limit(timeLimit), .hit(timeHit)
  );
  limit_compare #(.W(EVT_W)) uEvtCmp (
    .count(eventCount), .limit(eventLimit), .hit(eventHit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeFlag  <= 1'b0;
      eventFlag <= 1'b0;
      levelQ    <= 1'b0;
    end else begin
      timeFlag  <= timeHit;
      eventFlag <= eventHit;
      levelQ    <= eventLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  alarmLatch <= 1'b0;
    else if (strobe.setAlarm)   alarmLatch <= 1'b1;
    else if (strobe.clearAlarm) alarmLatch <= 1'b0;
  end

  assign statusByte   = {5'b0, levelQ, eventFlag, timeFlag};
  // Polarity 0: active pulls low. Polarity 1: active releases.
  assign alarmDriveEn = alarmLatch ^ polarity;
  assign alarmPin     = ~alarmDriveEn;
endmodule

// File: rtl/alarm_control.sv
module alarm_control
  import alarm_pkg::*;
(
  input  logic         timeFlag,
  input  logic         eventFlag,
  input  logic         timeEn,
  input  logic         eventEn,
  input  logic         clearStrobe,
  output alarmStrobe_t strobe
);
  logic anySet;
  assign anySet            = (timeEn & timeFlag) | (eventEn & eventFlag);
  assign strobe.setAlarm   = anySet;
  assign strobe.clearAlarm = clearStrobe & ~anySet;
endmodule

// File: rtl/threshold_alarm.sv
module threshold_alarm
  import alarm_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int EVT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] timeCount,
  input  logic [EVT_W-1:0]  eventCount,
  input  logic              eventLevel,
  input  logic [7:0]        cfgByte,
  input  logic [TIME_W-1:0] timeLimit,
  input  logic [EVT_W-1:0]  eventLimit,
  input  logic              clearStrobe,
  output logic [7:0]        statusByte,
  output logic              alarmDriveEn,
  output logic              alarmPin
);
  alarmStrobe_t strobe;
  logic timeFlag, eventFlag;

  alarm_control uCtl (
    .timeFlag(timeFlag), .eventFlag(eventFlag),
    .timeEn(cfgByte[CFG_TIME_EN]), .eventEn(cfgByte[CFG_EVT_EN]),
    .clearStrobe(clearStrobe), .strobe(strobe)
  );

  alarm_datapath #(.TIME_W(TIME_W), .EVT_W(EVT_W)) uDp (
    .clk(clk), .rstN(rstN), .timeCount(timeCount), .eventCount(eventCount),
    .eventLevel(eventLevel), .timeLimit(timeLimit), .eventLimit(eventLimit),
    .polarity(cfgByte[CFG_POL]), .strobe(strobe),
    .timeFlag(timeFlag), .eventFlag(eventFlag), .statusByte(statusByte),
    .alarmDriveEn(alarmDriveEn), .alarmPin(alarmPin)
  );
endmodule

// File: rtl/threshold_alarm_checker.sv
module threshold_alarm_checker #(
  parameter int TIME_W = 32,
  parameter int EVT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [TIME_W-1:0] timeCount,
  input logic [EVT_W-1:0]  eventCount,
  input logic [7:0]        cfgByte,
  input logic [TIME_W-1:0] timeLimit,
  input logic [EVT_W-1:0]  eventLimit,
  input logic              clearStrobe,
  input logic [7:0]        statusByte,
  input logic              alarmDriveEn
);
  logic armed;
  logic active;
  logic enabledSet;

  always_ff @(posedge clk) armed <= rstN;

  assign active     = alarmDriveEn ^ cfgByte[0];
  assign enabledSet = (cfgByte[2] & statusByte[0]) | (cfgByte[1] & statusByte[1]);

  assert_time_flag_R2: assert property (@(posedge clk) disable iff (!rstN || !armed)
    statusByte[0] == $past((timeLimit != '0) && (timeCount >= timeLimit)));

  assert_event_flag_R3: assert property (@(posedge clk) disable iff (!rstN || !armed)
    statusByte[1] == $past((eventLimit != '0) && (eventCount >= eventLimit)));

  assert_zero_limit_R4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    $past(timeLimit == '0) |-> !statusByte[0]);

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7:3] == 5'b0);

  assert_set_R6: assert property (@(posedge clk) disable iff (!rstN || !armed)
    $past(enabledSet) |-> active);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN || !armed)
    ($past(active) && !$past(clearStrobe)) |-> active);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN || !armed)
    $past(clearStrobe && !enabledSet) |-> !active);
endmodule

bind threshold_alarm threshold_alarm_checker #(.TIME_W(TIME_W), .EVT_W(EVT_W)) uChk (
  .clk(clk), .rstN(rstN), .timeCount(timeCount), .eventCount(eventCount),
  .cfgByte(cfgByte), .timeLimit(timeLimit), .eventLimit(eventLimit),
  .clearStrobe(clearStrobe), .statusByte(statusByte), .alarmDriveEn(alarmDriveEn)
);

// File: tb/sim_threshold_alarm.sv
module sim_threshold_alarm;
  localparam int TW = 4;
  localparam int EW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [TW-1:0] timeCount = '0, timeLimit = '0;
  logic [EW-1:0] eventCount = '0, eventLimit = '0;
  logic          eventLevel = 1'b0, clearStrobe = 1'b0;
  logic [7:0]    cfgByte = 8'h00;
  logic [7:0]    statusByte;
  logic          alarmDriveEn, alarmPin;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  threshold_alarm #(.TIME_W(TW), .EVT_W(EW)) u0 (
    .clk(clk), .rstN(rstN), .timeCount(timeCount), .eventCount(eventCount),
    .eventLevel(eventLevel), .cfgByte(cfgByte), .timeLimit(timeLimit),
    .eventLimit(eventLimit), .clearStrobe(clearStrobe), .statusByte(statusByte),
    .alarmDriveEn(alarmDriveEn), .alarmPin(alarmPin)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Alarm pins for an expected active state under the current polarity
  task automatic checkAlarm(input string tag, input bit act);
    bit expDrive;
    expDrive = act ^ cfgByte[0];
    check({tag, " driveEn"}, int'(alarmDriveEn), int'(expDrive));
    check({tag, " pin"}, int'(alarmPin), int'(!expDrive));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 status in reset", int'(statusByte), 0);
    rstN = 1'b1;
    step();
    check("R1 status after reset", int'(statusByte), 0);
    checkAlarm("R1 idle", 1'b0);

    // R2/R4: exhaustive time compare, alarm sources disabled
    for (int tl = 0; tl < (1 << TW); tl++) begin
      for (int tc = 0; tc < (1 << TW); tc++) begin
        timeLimit = TW'(tl);
        timeCount = TW'(tc);
        step();
        check(tl == 0 ? "R4 time zero limit" : "R2 time flag",
              int'(statusByte[0]), int'(tl != 0 && tc >= tl));
      end
    end
    timeLimit = '0;
    timeCount = '0;

    // R3/R4/R5: exhaustive event compare with level toggling
    for (int el = 0; el < (1 << EW); el++) begin
      for (int ec = 0; ec < (1 << EW); ec++) begin
        eventLimit = EW'(el);
        eventCount = EW'(ec);
        eventLevel = ec[0] ^ el[0];
        step();
        check(el == 0 ? "R4 event zero limit" : "R3 event flag",
              int'(statusByte[1]), int'(el != 0 && ec >= el));
        check("R5 level bit", int'(statusByte[2]), int'(ec[0] ^ el[0]));
        check("R5 upper bits", int'(statusByte[7:3]), 0);
      end
    end
    check("R6 disabled sources keep alarm off", int'(alarmDriveEn), 0);
    eventLimit = '0;
    eventCount = '0;
    eventLevel = 1'b0;
    step();

    // R6/R7/R8/R9: time source, polarity 0
    cfgByte   = 8'b100;
    timeLimit = 4'd5;
    timeCount = 4'd3;
    step(); step();
    checkAlarm("R6 below limit", 1'b0);
    timeCount = 4'd5;
    step();
    checkAlarm("R6 flag only, latch not yet", 1'b0);
    step();
    checkAlarm("R6 R9 active low", 1'b1);
    timeCount = 4'd2;
    step(); step(); step();
    check("R2 flag cleared by itself", int'(statusByte[0]), 0);
    checkAlarm("R7 held after flag clears", 1'b1);
    cfgByte = 8'b101;
    #1;
    checkAlarm("R9 active high releases", 1'b1);
    cfgByte = 8'b100;
    clearStrobe = 1'b1;
    step();
    clearStrobe = 1'b0;
    checkAlarm("R8 clear releases", 1'b0);

    // R8: clear while condition still present
    timeCount = 4'd9;
    step(); step();
    checkAlarm("R6 re-set", 1'b1);
    clearStrobe = 1'b1;
    step();
    clearStrobe = 1'b0;
    checkAlarm("R8 clear with condition present", 1'b1);

    // R8: clear strobe in the same cycle as a fresh set
    timeCount = 4'd1;
    step();
    clearStrobe = 1'b1;
    step();
    clearStrobe = 1'b0;
    checkAlarm("R8 cleared before race", 1'b0);
    timeCount = 4'd7;
    step();
    clearStrobe = 1'b1;
    step();
    clearStrobe = 1'b0;
    checkAlarm("R8 set wins over clear", 1'b1);

    // R9: inactive with polarity 1 drives low
    timeCount = 4'd0;
    cfgByte = 8'b101;
    step();
    clearStrobe = 1'b1;
    step();
    clearStrobe = 1'b0;
    checkAlarm("R9 inactive active-high drives low", 1'b0);
    check("R9 inactive pol1 driveEn", int'(alarmDriveEn), 1);

    // R6: time flag set but only event enabled
    cfgByte   = 8'b010;
    timeCount = 4'd12;
    step(); step(); step();
    check("R2 flag set", int'(statusByte[0]), 1);
    checkAlarm("R6 disabled time source", 1'b0);
    eventLimit = 3'd2;
    eventCount = 3'd3;
    step(); step();
    checkAlarm("R6 event source sets", 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule